// File: doc/BRIEF.md
# Delay-Chain Timing Monitor Controller

This block is the digital half of a closed-loop supply controller. The replica of the critical path is an analog delay chain. The controller fires a launch edge into that chain for one clock cycle. At the end of the same cycle it captures the tap buffers as a vector. It decodes how many stages the edge crossed and then asks an external regulator to step the supply code up or down. The aim is to keep the edge landing on a chosen stage plus a safety margin of extra stages.

A calibration write picks which chain output feeds the capture buffers. Run-time inputs set the target stage, the margin, a hysteresis band, a settle wait after each supply step, and the floor and ceiling of the supply code. A capture that is not a clean thermometer pattern is treated as a timing failure and raises the supply.

Top module: `dlymon_ctrl`

## Requirements
- R1: The chain output select `chain_sel_o` takes the value of `cal_tap_i` on a clock edge where `cal_load_i` is high. It holds that value at all other times, whatever `cal_tap_i` does. It resets to 0.
- R2: `launch_o` is high for exactly one cycle per measurement. `taps_i` is captured at the end of that cycle, and `launch_o` is low in the following cycle, so launches are at least two cycles apart. With enable held, a settle count of 0 and no supply step, a launch occurs every second cycle. `meas_valid_o` pulses two cycles after each launch.
- R3: In the `meas_valid_o` cycle, `stage_o` equals the number of consecutive ones in the captured vector counting up from bit 0 (bit 0 is the first stage). `bubble_o` is 1 when any bit above the first zero is 1.
- R4: When the stage is below target+margin, the supply code rises by 1 and `step_up_o` pulses in the `meas_valid_o` cycle.
- R5: When the stage is at or above target+margin+H, the code falls by 1 and `step_down_o` pulses in the `meas_valid_o` cycle. H is `hyst_i`, except that a value of 0 is used as 1.
- R6: A capture with a bubble always raises the code, whatever its stage.
- R7: A stage inside the band (from target+margin up to, but not including, the lower threshold) leaves the code unchanged, with no step pulse.
- R8: After a step, the next launch comes exactly `settle_i` cycles after the cycle in which the step pulse is visible.
- R9: The code never goes above `vmax_i` or below `vmin_i`. At a limit, a request in that direction gives no step pulse.
- R10: In reset, `vcode_o` equals the parameter V_RESET and all pulse outputs are low. With `enable_i` low, no new launch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the measurement loop |
| cal_load_i | input | 1 | Load the chain output select |
| cal_tap_i | input | SELW | Calibration value for the chain output select |
| target_i | input | IW | Target stage |
| margin_i | input | IW | Safety margin in stages |
| hyst_i | input | IW | Hysteresis band in stages (0 is used as 1) |
| settle_i | input | CW | Wait in cycles after a supply step |
| vmin_i | input | VW | Lowest supply code |
| vmax_i | input | VW | Highest supply code |
| taps_i | input | NTAP | Tap buffer outputs from the chain |
| launch_o | output | 1 | Launch edge into the chain |
| chain_sel_o | output | SELW | Selected chain output |
| vcode_o | output | VW | Supply code to the regulator |
| step_up_o | output | 1 | Supply raised this cycle |
| step_down_o | output | 1 | Supply lowered this cycle |
| meas_valid_o | output | 1 | Measurement result valid |
| stage_o | output | IW | Decoded stage |
| bubble_o | output | 1 | Capture was not a thermometer code |

## Verification
The bench builds the block with a 16-stage chain, a 6-bit supply code reset to 20 and a 4-bit settle counter. With these values, the all-ones and all-zeros captures, both supply limits and multi-cycle settle gaps can all be reached in a few dozen cycles. A simple chain model reports half the supply code as the stage reached. The loop therefore has to settle on a known code from the reset value. Forced capture patterns cover bubbles, the band edges and a hysteresis input of zero.

// File: rtl/dlymon_pkg.sv
package dlymon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_EVAL,
    ST_SETTLE
  } mon_state_e;

  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_UP,
    ACT_DOWN
  } act_e;
endpackage

// File: rtl/dlymon_therm_dec.sv
module dlymon_therm_dec #(
  parameter int NTAP = 16,
  parameter int IW   = $clog2(NTAP + 1)
) (
  input  logic [NTAP-1:0] taps_i,
  output logic [IW-1:0]   stage_o,
  output logic            bubble_o
);
  // run[i] is high while every stage up to i has seen the edge
  logic [NTAP-1:0] run;

  generate
    for (genvar i = 0; i < NTAP; i++) begin : g_run
      if (i == 0) begin : g_first
        assign run[i] = taps_i[i];
      end else begin : g_rest
        assign run[i] = run[i-1] & taps_i[i];
      end
    end
  endgenerate

  always_comb begin
    stage_o = '0;
    for (int i = 0; i < NTAP; i++) begin
      stage_o = stage_o + IW'(run[i]);
    end
  end

  // any one beyond the first zero breaks the thermometer pattern
  assign bubble_o = |(taps_i & ~run);
endmodule

// File: rtl/dlymon_decide.sv
module dlymon_decide
  import dlymon_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic [IW-1:0] stage_i,
  input  logic          bubble_i,
  input  logic [IW-1:0] target_i,
  input  logic [IW-1:0] margin_i,
  input  logic [IW-1:0] hyst_i,
  output act_e          act_o
);
  localparam int SW = IW + 2;

  logic [SW-1:0] need;
  logic [SW-1:0] upper;
  logic [SW-1:0] hyst_e;
  logic [SW-1:0] stage_w;

  always_comb begin
    hyst_e  = (hyst_i == '0) ? SW'(1) : SW'(hyst_i);
    need    = SW'(target_i) + SW'(margin_i);
    upper   = need + hyst_e;
    stage_w = SW'(stage_i);
    if (bubble_i || (stage_w < need)) begin
      act_o = ACT_UP;
    end else if (stage_w >= upper) begin
      act_o = ACT_DOWN;
    end else begin
      act_o = ACT_HOLD;
    end
  end
endmodule

// File: rtl/dlymon_vreg.sv
module dlymon_vreg
  import dlymon_pkg::*;
#(
  parameter int VW      = 6,
  parameter int V_RESET = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply_i,
  input  act_e          act_i,
  input  logic [VW-1:0] vmin_i,
  input  logic [VW-1:0] vmax_i,
  output logic [VW-1:0] vcode_o,
  output logic          up_o,
  output logic          dn_o,
  output logic          take_o
);
  logic          up_ok;
  logic          dn_ok;
  logic [VW-1:0] vcode_n;

  always_comb begin
    up_ok   = (act_i == ACT_UP)   && (vcode_o < vmax_i);
    dn_ok   = (act_i == ACT_DOWN) && (vcode_o > vmin_i);
    take_o  = apply_i && (up_ok || dn_ok);
    vcode_n = vcode_o;
    if (apply_i && up_ok) begin
      vcode_n = vcode_o + 1'b1;
    end else if (apply_i && dn_ok) begin
      vcode_n = vcode_o - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcode_o <= VW'(V_RESET);
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
    end else begin
      vcode_o <= vcode_n;
      up_o    <= apply_i && up_ok;
      dn_o    <= apply_i && dn_ok;
    end
  end
endmodule

// File: rtl/dlymon_ctrl.sv
module dlymon_ctrl
  import dlymon_pkg::*;
#(
  parameter int NTAP       = 16,
  parameter int CHAIN_OUTS = 8,
  parameter int VW         = 6,
  parameter int CW         = 4,
  parameter int V_RESET    = 20,
  localparam int IW        = $clog2(NTAP + 1),
  localparam int SELW      = $clog2(CHAIN_OUTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic            cal_load_i,
  input  logic [SELW-1:0] cal_tap_i,
  input  logic [IW-1:0]   target_i,
  input  logic [IW-1:0]   margin_i,
  input  logic [IW-1:0]   hyst_i,
  input  logic [CW-1:0]   settle_i,
  input  logic [VW-1:0]   vmin_i,
  input  logic [VW-1:0]   vmax_i,
  input  logic [NTAP-1:0] taps_i,
  output logic            launch_o,
  output logic [SELW-1:0] chain_sel_o,
  output logic [VW-1:0]   vcode_o,
  output logic            step_up_o,
  output logic            step_down_o,
  output logic            meas_valid_o,
  output logic [IW-1:0]   stage_o,
  output logic            bubble_o
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync <= 2'b00;
    end else begin
      rsync <= {rsync[0], 1'b1};
    end
  end
  assign rst_ni = rsync[1];

  // calibration select
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_sel_o <= '0;
    end else if (cal_load_i) begin
      chain_sel_o <= cal_tap_i;
    end
  end

  // sequencer
  mon_state_e    state_q, state_n;
  logic [CW-1:0] wait_q, wait_n;
  logic [NTAP-1:0] cap_q;
  logic          take;
  logic          in_eval;
  logic [IW-1:0] dec_stage;
  logic          dec_bubble;
  act_e          act;

  assign in_eval  = (state_q == ST_EVAL);
  assign launch_o = (state_q == ST_LAUNCH);

  always_comb begin
    state_n = state_q;
    wait_n  = wait_q;
    unique case (state_q)
      ST_IDLE: begin
        if (enable_i) state_n = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        state_n = ST_EVAL;
      end
      ST_EVAL: begin
        if (take && (settle_i != '0)) begin
          state_n = ST_SETTLE;
          wait_n  = settle_i;
        end else begin
          state_n = enable_i ? ST_LAUNCH : ST_IDLE;
        end
      end
      ST_SETTLE: begin
        wait_n = wait_q - 1'b1;
        if (wait_q <= CW'(1)) begin
          state_n = enable_i ? ST_LAUNCH : ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
    end else begin
      state_q <= state_n;
      wait_q  <= wait_n;
    end
  end

  // capture at the end of the launch cycle
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (launch_o) begin
      cap_q <= taps_i;
    end
  end

  dlymon_therm_dec #(.NTAP(NTAP), .IW(IW)) u_dec (
    .taps_i   (cap_q),
    .stage_o  (dec_stage),
    .bubble_o (dec_bubble)
  );

  dlymon_decide #(.IW(IW)) u_decide (
    .stage_i  (dec_stage),
    .bubble_i (dec_bubble),
    .target_i (target_i),
    .margin_i (margin_i),
    .hyst_i   (hyst_i),
    .act_o    (act)
  );

  dlymon_vreg #(.VW(VW), .V_RESET(V_RESET)) u_vreg (
    .clk     (clk),
    .rst_n   (rst_ni),
    .apply_i (in_eval),
    .act_i   (act),
    .vmin_i  (vmin_i),
    .vmax_i  (vmax_i),
    .vcode_o (vcode_o),
    .up_o    (step_up_o),
    .dn_o    (step_down_o),
    .take_o  (take)
  );

  // measurement report
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_valid_o <= 1'b0;
      stage_o      <= '0;
      bubble_o     <= 1'b0;
    end else begin
      meas_valid_o <= in_eval;
      if (in_eval) begin
        stage_o  <= dec_stage;
        bubble_o <= dec_bubble;
      end
    end
  end
endmodule

// File: rtl/dlymon_ctrl_chk.sv
module dlymon_ctrl_chk #(
  parameter int VW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          launch_o,
  input logic          meas_valid_o,
  input logic          bubble_o,
  input logic          step_up_o,
  input logic          step_down_o,
  input logic [VW-1:0] vcode_o,
  input logic [VW-1:0] vmin_i,
  input logic [VW-1:0] vmax_i
);
  p_launch_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> !launch_o);

  p_meas_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid_o |-> $past(launch_o, 2));

  p_step_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up_o && step_down_o));

  p_step_meas_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up_o || step_down_o) |-> meas_valid_o);

  p_up_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_o |-> (vcode_o == VW'($past(vcode_o) + 1'b1)));

  p_dn_decr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_down_o |-> (vcode_o == VW'($past(vcode_o) - 1'b1)));

  p_bubble_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid_o && bubble_o) |-> !step_down_o);

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up_o || step_down_o) |-> $stable(vcode_o));

  p_vmax_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_up_o |-> (vcode_o <= vmax_i));

  p_vmin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_down_o |-> (vcode_o >= vmin_i));
endmodule

bind dlymon_ctrl dlymon_ctrl_chk #(.VW(VW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .launch_o     (launch_o),
  .meas_valid_o (meas_valid_o),
  .bubble_o     (bubble_o),
  .step_up_o    (step_up_o),
  .step_down_o  (step_down_o),
  .vcode_o      (vcode_o),
  .vmin_i       (vmin_i),
  .vmax_i       (vmax_i)
);

// File: tb/dlymon_ctrl_test.sv
module dlymon_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTAP = 16;
  localparam int VW   = 6;
  localparam int CW   = 4;
  localparam int VRST = 20;
  localparam int IW   = 5;
  localparam int SELW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic enable_i, cal_load_i;
  logic [SELW-1:0] cal_tap_i;
  logic [IW-1:0] target_i, margin_i, hyst_i;
  logic [CW-1:0] settle_i;
  logic [VW-1:0] vmin_i, vmax_i;
  logic [NTAP-1:0] taps_i, model_taps, forced;
  logic use_model;
  logic launch_o, step_up_o, step_down_o, meas_valid_o, bubble_o;
  logic [SELW-1:0] chain_sel_o;
  logic [VW-1:0] vcode_o;
  logic [IW-1:0] stage_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // chain model: stage reached is half the supply code
  always_comb begin
    for (int i = 0; i < NTAP; i++) model_taps[i] = (i < int'(vcode_o >> 1));
  end
  assign taps_i = use_model ? model_taps : forced;

  dlymon_ctrl #(.NTAP(NTAP), .CHAIN_OUTS(8), .VW(VW), .CW(CW), .V_RESET(VRST)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .cal_load_i(cal_load_i),
    .cal_tap_i(cal_tap_i), .target_i(target_i), .margin_i(margin_i),
    .hyst_i(hyst_i), .settle_i(settle_i), .vmin_i(vmin_i), .vmax_i(vmax_i),
    .taps_i(taps_i), .launch_o(launch_o), .chain_sel_o(chain_sel_o),
    .vcode_o(vcode_o), .step_up_o(step_up_o), .step_down_o(step_down_o),
    .meas_valid_o(meas_valid_o), .stage_o(stage_o), .bubble_o(bubble_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    enable_i = 0; cal_load_i = 0; cal_tap_i = '0;
    target_i = 5'd6; margin_i = 5'd2; hyst_i = 5'd1; settle_i = '0;
    vmin_i = '0; vmax_i = 6'd63; use_model = 0; forced = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_meas();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (meas_valid_o) return;
    end
  endtask

  // one measurement of a forced pattern, from idle
  task automatic measure_once(input logic [NTAP-1:0] pat, output int vb);
    enable_i = 0;
    repeat (8) @(negedge clk);
    forced = pat; use_model = 0;
    vb = int'(vcode_o);
    enable_i = 1;
    wait_meas();
    enable_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check(vcode_o == VW'(VRST), "R10 reset code", int'(vcode_o), VRST);
    check(!launch_o && !step_up_o && !step_down_o && !meas_valid_o,
          "R10 reset pulses", int'({launch_o, step_up_o, step_down_o, meas_valid_o}), 0);
  endtask

  task automatic t_cal();
    do_reset();
    check(chain_sel_o == '0, "R1 select reset", int'(chain_sel_o), 0);
    cal_tap_i = 3'd5; cal_load_i = 1;
    @(negedge clk);
    cal_load_i = 0;
    check(chain_sel_o == 3'd5, "R1 select load", int'(chain_sel_o), 5);
    cal_tap_i = 3'd2;
    repeat (4) @(negedge clk);
    check(chain_sel_o == 3'd5, "R1 select held", int'(chain_sel_o), 5);
  endtask

  task automatic t_cadence();
    int n = 0;
    bit consec = 0;
    bit prev = 0;
    do_reset();
    forced = 16'h00FF; enable_i = 1;
    for (int i = 0; i < 100 && !launch_o; i++) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (launch_o) n++;
      if (launch_o && prev) consec = 1;
      prev = launch_o;
      @(negedge clk);
    end
    check(n == 20, "R2 launch every second cycle", n, 20);
    check(!consec, "R2 no back-to-back launch", int'(consec), 0);
    check(stage_o == 5'd8 && !bubble_o, "R3 stage at target", int'(stage_o), 8);
    check(vcode_o == VW'(VRST), "R7 hold in band", int'(vcode_o), VRST);
    enable_i = 0;
    repeat (6) @(negedge clk);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (launch_o) n++;
      @(negedge clk);
    end
    check(n == 0, "R10 no launch when disabled", n, 0);
  endtask

  task automatic t_decode();
    int vb;
    do_reset();
    measure_once(16'h0007, vb);
    check(stage_o == 5'd3 && !bubble_o, "R3 stage three", int'(stage_o), 3);
    measure_once(16'h0000, vb);
    check(stage_o == 5'd0 && !bubble_o, "R3 stage zero", int'(stage_o), 0);
    measure_once(16'hFFFF, vb);
    check(stage_o == 5'd16 && !bubble_o, "R3 full chain", int'(stage_o), 16);
    measure_once(16'h00F7, vb);
    check(stage_o == 5'd3, "R3 stage before bubble", int'(stage_o), 3);
    check(bubble_o, "R3 bubble flag", int'(bubble_o), 1);
  endtask

  task automatic t_updown();
    int vb;
    do_reset();
    target_i = 5'd4; margin_i = 5'd1; hyst_i = 5'd3;
    measure_once(16'h000F, vb);
    check(step_up_o && vcode_o == VW'(vb + 1), "R4 short edge raises", int'(vcode_o), vb + 1);
    measure_once(16'h001F, vb);
    check(!step_up_o && !step_down_o && vcode_o == VW'(vb), "R7 band low edge holds", int'(vcode_o), vb);
    measure_once(16'h007F, vb);
    check(!step_up_o && !step_down_o && vcode_o == VW'(vb), "R7 band high edge holds", int'(vcode_o), vb);
    measure_once(16'h00FF, vb);
    check(step_down_o && vcode_o == VW'(vb - 1), "R5 slack lowers", int'(vcode_o), vb - 1);
    hyst_i = 5'd0;
    measure_once(16'h003F, vb);
    check(step_down_o && vcode_o == VW'(vb - 1), "R5 zero band used as one", int'(vcode_o), vb - 1);
    measure_once(16'h001F, vb);
    check(!step_down_o && vcode_o == VW'(vb), "R5 zero band holds at need", int'(vcode_o), vb);
    target_i = 5'd0; margin_i = 5'd0;
    measure_once(16'hFFF7, vb);
    check(step_up_o && vcode_o == VW'(vb + 1), "R6 bubble raises", int'(vcode_o), vb + 1);
  endtask

  task automatic t_settle(input int s);
    int gap = 0;
    do_reset();
    settle_i = CW'(s); forced = '0; enable_i = 1;
    for (int i = 0; i < 100 && !step_up_o; i++) @(negedge clk);
    while (!launch_o && gap < 50) begin
      gap++;
      @(negedge clk);
    end
    check(gap == s, "R8 settle gap", gap, s);
    enable_i = 0;
  endtask

  task automatic t_sat();
    int ups = 0;
    do_reset();
    vmax_i = 6'd22; forced = '0; enable_i = 1;
    repeat (30) @(negedge clk);
    check(vcode_o == 6'd22, "R9 ceiling", int'(vcode_o), 22);
    for (int i = 0; i < 20; i++) begin
      if (step_up_o) ups++;
      @(negedge clk);
    end
    check(ups == 0, "R9 no pulse at ceiling", ups, 0);
    enable_i = 0;
    repeat (6) @(negedge clk);
    vmin_i = 6'd5; target_i = '0; margin_i = '0; hyst_i = 5'd1;
    forced = 16'hFFFF; enable_i = 1;
    repeat (80) @(negedge clk);
    check(vcode_o == 6'd5, "R9 floor", int'(vcode_o), 5);
    enable_i = 0;
  endtask

  task automatic t_converge();
    do_reset();
    use_model = 1; enable_i = 1;
    repeat (60) @(negedge clk);
    check(vcode_o == 6'd17, "R5 loop settles on band", int'(vcode_o), 17);
    enable_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cal();
    t_cadence();
    t_decode();
    t_updown();
    t_settle(0);
    t_settle(3);
    t_sat();
    t_converge();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule